// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block turns one source clock into two slower audio clocks: a master clock for converters and a serial bit clock for the data lines. The division is done in stages. An optional prescaler divides by 1 or by 8. A modulus stage divides by any value from 1 to 256. A fixed halving stage comes next and gives the master clock. A tail stage then divides the master clock by 1 to 16 to give the bit clock.

All counting is done in the source clock domain, so every divided output is a register. Each output has a companion tick. The tick is high during the first source cycle of each high phase, so logic clocked by the source can follow either clock without crossing clock domains.

A full-bypass control skips the prescaler, the modulus stage and the halving stage. In that case the source clock itself appears on the master clock output, and the tail stage counts source cycles directly. Each divider field is written as the divide value minus one. A new field value is taken up only when its stage next reaches terminal count.

Top module: `audio_clk_divider`

## Requirements
- R1: With `pre_en` = 0 the prescaler passes every source cycle. With `pre_en` = 1 it divides by 8. In divided mode a master clock half period therefore lasts M source cycles in the first case and 8·M cycles in the second.
- R2: The modulus field `pm_sel` holds M−1, so the value 0 gives M = 1 and the value 255 gives M = 256. Every M from 1 to 256 sets the master clock half period to P·M source cycles, where P is the prescaler factor.
- R3: In divided mode the master clock has exactly 50% duty and a period of 2·P·M source cycles, so the source-to-master ratio is always even and at least 2.
- R4: The tail field `fp_sel` holds F−1. In divided mode the bit clock has a period of F master clock periods and exactly 50% duty. Each bit clock rising edge falls on a master clock rising edge.
- R5: With `full_bypass` = 1 the master clock equals the source clock. The bit clock then has a period of F source cycles and stays high for ceil(F/2) of them, so for odd F the high phase is one cycle longer. For F = 1 the bit clock also equals the source clock.
- R6: With P = 8, M = 256 and F = 16, one bit clock period spans the largest ratio, 65536 source cycles.
- R7: A new value on `pre_en`, `pm_sel` or `fp_sel` is loaded only at that stage's next terminal count. The half period or bit clock period already running completes at its old length, so no runt pulse occurs.
- R8: While `rst` is high, all four outputs are low. After `rst` is released in divided mode, the master clock and the bit clock both rise P·M source edges later.
- R9: In divided mode `mclk_tick` and `bclk_tick` are each high for exactly one source cycle: the first cycle of each high phase of their clock. In bypass `mclk_tick` stays high and `bclk_tick` marks the first cycle of each bit clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| pre_en | input | 1 | 1 selects the divide-by-8 prescaler |
| pm_sel | input | PM_W | Modulus divide value minus one |
| fp_sel | input | FP_W | Bit clock divide value minus one |
| full_bypass | input | 1 | Routes the source clock straight to the master clock |
| mclk | output | 1 | Master clock |
| mclk_tick | output | 1 | First source cycle of each master clock high phase |
| bclk | output | 1 | Bit clock |
| bclk_tick | output | 1 | First source cycle of each bit clock high phase |

## Verification
The bench builds the block with its default widths: an 8-bit modulus field, a 4-bit tail field and a prescale factor of 8. With these values every stage can reach its extreme settings. That includes the full 65536-cycle bit clock period, which fits in a single run. Because both M and F can be odd, the bench checks 50% duty in divided mode and the uneven high phase in bypass. Field changes made in the middle of a run are checked against the expected lengths of the running and the following periods.

// File: rtl/audio_clk_divider.sv
module audio_clk_divider #(
  parameter int PM_W    = 8,
  parameter int FP_W    = 4,
  parameter int PRE_DIV = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pre_en,
  input  logic [PM_W-1:0] pm_sel,
  input  logic [FP_W-1:0] fp_sel,
  input  logic            full_bypass,
  output logic            mclk,
  output logic            mclk_tick,
  output logic            bclk,
  output logic            bclk_tick
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam int BC_W  = FP_W + 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic             pre_q;
  logic [PM_W-1:0]  pm_cnt, pm_q;
  logic [FP_W-1:0]  fp_q;
  logic [BC_W-1:0]  bc, span, hi_last, bc_inc;
  logic             mclk_q, bclk_q, mtick_q, btick_q;
  logic             tick_a, tick_b, step, wrap, src_gate;

  assign tick_a  = !pre_q || (pre_cnt == PRE_LAST);
  assign tick_b  = tick_a && (pm_cnt == pm_q);
  assign step    = full_bypass || tick_b;
  assign span    = full_bypass ? BC_W'(fp_q) : {fp_q, 1'b1};
  assign hi_last = full_bypass ? BC_W'(fp_q >> 1) : BC_W'(fp_q);
  assign wrap    = bc >= span;
  assign bc_inc  = bc + BC_W'(1);

  always_ff @(posedge clk) begin
    if (rst || tick_a) begin
      pre_cnt <= '0;
      pre_q   <= pre_en;
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || tick_b) begin
      pm_cnt <= '0;
      pm_q   <= pm_sel;
    end else if (tick_a) begin
      pm_cnt <= pm_cnt + PM_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_q  <= 1'b0;
      mtick_q <= 1'b0;
    end else begin
      if (tick_b) mclk_q <= !mclk_q;
      mtick_q <= full_bypass || (tick_b && !mclk_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bc      <= full_bypass ? BC_W'(fp_sel) : {fp_sel, 1'b1};
      fp_q    <= fp_sel;
      bclk_q  <= 1'b0;
      btick_q <= 1'b0;
    end else begin
      btick_q <= step && wrap;
      if (step) begin
        if (wrap) begin
          bc     <= '0;
          fp_q   <= fp_sel;
          bclk_q <= 1'b1;
        end else begin
          bc     <= bc_inc;
          bclk_q <= bc_inc <= hi_last;
        end
      end
    end
  end

  assign src_gate  = clk && !rst;
  assign mclk      = full_bypass ? src_gate : mclk_q;
  assign bclk      = (full_bypass && fp_q == '0) ? src_gate : bclk_q;
  assign mclk_tick = mtick_q;
  assign bclk_tick = btick_q;
endmodule

module audio_clk_divider_chk (
  input logic clk,
  input logic rst,
  input logic full_bypass,
  input logic mclk,
  input logic mclk_tick,
  input logic bclk,
  input logic bclk_tick
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen && rst)
      p_reset_quiet_r8: assert (!mclk && !bclk && !mclk_tick && !bclk_tick);
  end

  p_mtick_on_rise_r9: assert property (@(posedge clk) disable iff (rst || full_bypass)
    mclk_tick |-> $rose(mclk));

  p_mtick_single_r9: assert property (@(posedge clk) disable iff (rst || full_bypass)
    mclk_tick |=> !mclk_tick);

  p_btick_on_mtick_r4: assert property (@(posedge clk) disable iff (rst || full_bypass)
    bclk_tick |-> mclk_tick);

  p_bclk_rise_ticks_r4: assert property (@(posedge clk) disable iff (rst || full_bypass)
    $rose(bclk) |-> bclk_tick);

  p_bypass_mtick_r5: assert property (@(posedge clk) disable iff (rst)
    (full_bypass && $past(full_bypass) && !$past(rst)) |-> mclk_tick);
endmodule

bind audio_clk_divider audio_clk_divider_chk u_chk (
  .clk(clk), .rst(rst), .full_bypass(full_bypass), .mclk(mclk),
  .mclk_tick(mclk_tick), .bclk(bclk), .bclk_tick(bclk_tick)
);

// File: tb/tb_audio_clk_divider.sv
`timescale 1ns/1ps
module tb_audio_clk_divider;
  logic       clk = 1'b0, rst = 1'b1, pre_en = 1'b0, full_bypass = 1'b0;
  logic [7:0] pm_sel = '0;
  logic [3:0] fp_sel = '0;
  logic       mclk, mclk_tick, bclk, bclk_tick;
  int checks = 0, fails = 0;
  bit finished = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  audio_clk_divider dut (
    .clk(clk), .rst(rst), .pre_en(pre_en), .pm_sel(pm_sel), .fp_sel(fp_sel),
    .full_bypass(full_bypass), .mclk(mclk), .mclk_tick(mclk_tick),
    .bclk(bclk), .bclk_tick(bclk_tick)
  );

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {mclk,mclk_tick,bclk,bclk_tick} actual %b expected %b at %0t",
               tag, act, exp, $time);
    end
  endtask

  // monitor: pops expected items pushed at each edge and compares
  always begin
    @(posedge clk);
    #1;
    while (exp_q.size() > 0) begin : pop_blk
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {mclk, mclk_tick, bclk, bclk_tick}, e);
    end
  end

  task automatic do_reset(bit p8, int pm, int fp, bit byp);
    @(negedge clk);
    rst = 1'b1; pre_en = p8; pm_sel = 8'(pm); fp_sel = 4'(fp); full_bypass = byp;
    @(negedge clk);
    @(negedge clk);
    chk("R8", {mclk, mclk_tick, bclk, bclk_tick}, 4'b0000);
    @(posedge clk);
    #1;
    chk("R8", {mclk, mclk_tick, bclk, bclk_tick}, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_div(bit p8, int pm, int fp, int n, string tag,
                         int chg_at = -1, int pm2 = 0, int fp2 = 0);
    int h, cnt, hp, fcur;
    bit m, b, mt, bt;
    do_reset(p8, pm, fp, 1'b0);
    h = (p8 ? 8 : 1) * (pm + 1);
    cnt = 0; fcur = fp + 1; hp = 2 * fcur - 1; m = 0; b = 0;
    for (int t = 1; t <= n; t++) begin
      @(posedge clk);
      mt = 0; bt = 0; cnt++;
      if (cnt == h) begin
        cnt = 0; m = !m; mt = m;
        h = (p8 ? 8 : 1) * (int'(pm_sel) + 1);
        hp++;
        if (hp == 2 * fcur) begin
          hp = 0; fcur = int'(fp_sel) + 1; b = 1; bt = 1;
        end else begin
          b = (hp < fcur);
        end
      end
      exp_q.push_back({m, mt, b, bt});
      tag_q.push_back(tag);
      if (t == chg_at) begin
        @(negedge clk);
        pm_sel = 8'(pm2); fp_sel = 4'(fp2);
      end
    end
  endtask

  task automatic run_byp(int fp, int n, string tag);
    int f, k;
    bit b;
    do_reset(1'b0, 0, fp, 1'b1);
    f = fp + 1;
    for (int t = 1; t <= n; t++) begin
      @(posedge clk);
      k = (t - 1) % f;
      b = (k < (f + 1) / 2);
      exp_q.push_back({1'b1, 1'b1, b, (k == 0)});
      tag_q.push_back(tag);
      #3;
      chk(tag, {mclk, bclk}, {1'b0, (f == 1) ? 1'b0 : b});
    end
  endtask

  initial begin
    run_div(1'b0, 0, 0, 40, "R3");
    run_div(1'b0, 4, 2, 120, "R2");
    run_div(1'b1, 2, 1, 300, "R1");
    run_div(1'b0, 2, 0, 60, "R1");
    run_div(1'b0, 255, 0, 1100, "R2");
    run_div(1'b0, 0, 15, 100, "R4");
    run_div(1'b0, 1, 4, 120, "R4");
    run_div(1'b1, 0, 2, 200, "R9");
    run_byp(0, 20, "R5");
    run_byp(2, 30, "R5");
    run_byp(3, 30, "R5");
    run_div(1'b0, 3, 0, 60, "R7", 5, 1, 0);
    run_div(1'b0, 1, 3, 200, "R7", 7, 1, 1);
    run_div(1'b1, 255, 15, 65536 + 2100, "R6");
    @(posedge clk);
    #2;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #950000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule